// File: doc/BRIEF.md
# 3-of-6 Transition-Coded Link Codec

This block holds the two ends of a six-wire link that carries 4-bit symbols with no strobe. The sending end takes a nibble through a valid/ready handshake and turns it into a codeword with exactly three ones. It sends the codeword by inverting those three wires. The receiving end compares the wire levels it sees now with the levels it last accepted. When exactly three wires differ, the pattern of the differing wires is a complete symbol. The receiver decodes that pattern, presents the nibble for one cycle, and inverts a single acknowledge wire. The sender may start the next symbol only after it has seen the acknowledge change.

The two ends are exposed separately, so the link wires and the acknowledge can be routed between dies, looped back, or disturbed for test. Both ends pass the signals that arrive from the link through a configurable chain of synchronising flops. Transitions that arrive in stages are collected until the count reaches three. Counts above three, and three-wire patterns outside the used set, are reported as errors. After an error the receiver takes the current wire levels as its new reference.

Top module: `tri_hex_link`

## Requirements
- R1: The codeword for nibble n is the (n+1)-th smallest 6-bit value with exactly three ones. Nibble 0 maps to 6'b000111, nibble 1 to 6'b001011, and nibble 15 to 6'b101100. The four 3-hot values with both bit 5 and bit 4 set (6'b110001, 6'b110010, 6'b110100, 6'b111000) are unused.
- R2: On a cycle with `tx_valid_i` and `tx_ready_o` both high, `tx_wires_o` is XORed with the codeword of `tx_data_i`. In every other cycle `tx_wires_o` holds its value.
- R3: `tx_ready_o` falls on the edge after a handshake. It rises again only after a change of `tx_ack_i` has passed the synchroniser. A change of `tx_ack_i` while the sender is idle leaves `tx_ready_o` high and `tx_wires_o` unchanged.
- R4: When the synchronised `rx_wires_i` differ from the reference in exactly three positions that form a used codeword, `rx_valid_o` is high for one cycle with the decoded nibble on `rx_data_o`. `rx_valid_o` rises SYNC_STAGES+1 clock edges after the edge that launched the change.
- R5: While fewer than three wires differ from the reference, the receiver produces no valid, no error and no acknowledge. Transitions that arrive in separate cycles add up to one symbol.
- R6: Three differing wires in an unused pattern give a one-cycle `rx_err_o` pulse and no `rx_valid_o`. The receiver then takes the current levels as its reference.
- R7: Four or more differing wires give a one-cycle `rx_err_o` pulse and no `rx_valid_o`. The receiver then takes the current levels as its reference.
- R8: `rx_ack_o` changes exactly once for each `rx_valid_o` or `rx_err_o` pulse, on the same edge, and at no other time.
- R9: While `rst_ni` is low, `tx_wires_o`, `rx_ack_o`, `rx_valid_o`, `rx_err_o` and the receiver reference are zero, and after reset `tx_ready_o` is high.
- R10: After an error and the resynchronisation that follows it, the next symbol is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 4 | Nibble to send |
| tx_valid_i | input | 1 | Sender has a nibble |
| tx_ready_o | output | 1 | Sender can take a nibble |
| tx_wires_o | output | 6 | Link wire levels driven by the sender |
| tx_ack_i | input | 1 | Acknowledge wire from the far receiver |
| rx_wires_i | input | 6 | Link wire levels arriving at the receiver |
| rx_ack_o | output | 1 | Acknowledge wire, changes once per resolved symbol |
| rx_data_o | output | 4 | Decoded nibble |
| rx_valid_o | output | 1 | One-cycle pulse, a nibble was accepted |
| rx_err_o | output | 1 | One-cycle pulse, a bad pattern was discarded |

## Verification
A wrong receiver reference does not stay hidden. The next symbol then shows the wrong number of differing wires. That gives either an error pulse or silence, and silence shows within SYNC_STAGES+1 edges as a missing valid and a sender that never gets ready again. A wrong sender wire state or a wrong codeword shows at the port on the edge after the handshake as a change that is not three-hot or does not match the table. A lost or doubled acknowledge shows as `tx_ready_o` staying low, or coming back while no symbol has been accepted.

// File: rtl/tri_hex_pkg.sv
package tri_hex_pkg;
  localparam int WIRES  = 6;
  localparam int HOT    = 3;
  localparam int DATA_W = 4;
  localparam int CODES  = 2 ** DATA_W;
  localparam int SPACE  = 2 ** WIRES;

  typedef logic [WIRES-1:0]  wires_t;
  typedef logic [DATA_W-1:0] nib_t;

  typedef struct packed {
    logic ok;
    nib_t nib;
  } dec_t;

  function automatic int unsigned ones(wires_t w);
    int unsigned c;
    c = 0;
    for (int i = 0; i < WIRES; i++) c += 32'(w[i]);
    return c;
  endfunction

  // rank among HOT-weight values in ascending order
  function automatic wires_t cw_enc(nib_t n);
    int unsigned rank;
    wires_t r;
    rank = 0;
    r = '0;
    for (int v = 0; v < SPACE; v++) begin
      if (ones(wires_t'(v)) == HOT) begin
        if (rank == 32'(n)) r = wires_t'(v);
        rank++;
      end
    end
    return r;
  endfunction

  function automatic dec_t cw_dec(wires_t w);
    dec_t d;
    int unsigned rank;
    d = '0;
    rank = 0;
    for (int v = 0; v < SPACE; v++) begin
      if (ones(wires_t'(v)) == HOT) begin
        if (wires_t'(v) == w && rank < CODES) begin
          d.ok  = 1'b1;
          d.nib = nib_t'(rank);
        end
        rank++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/tri_hex_sync.sv
module tri_hex_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (STAGES == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_chain
    logic [W-1:0] st_q [STAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
        st_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
    end
    assign q_o = st_q[STAGES-1];
  end
endmodule

// File: rtl/tri_hex_tx.sv
module tri_hex_tx
  import tri_hex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  nib_t   data_i,
  input  logic   valid_i,
  output logic   ready_o,
  output wires_t wires_o,
  input  logic   ack_i
);
  logic   ack_s, ack_ref_q, busy_q, hs;
  wires_t wires_q;

  tri_hex_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  assign ready_o = !busy_q;
  assign hs      = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wires_q   <= '0;
      busy_q    <= 1'b0;
      ack_ref_q <= 1'b0;
    end else begin
      ack_ref_q <= ack_s;  // edges while idle are consumed here
      if (hs) begin
        wires_q <= wires_q ^ cw_enc(data_i);
        busy_q  <= 1'b1;
      end else if (ack_s != ack_ref_q) begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign wires_o = wires_q;
endmodule

// File: rtl/tri_hex_rx.sv
module tri_hex_rx
  import tri_hex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  wires_t wires_i,
  output logic   ack_o,
  output nib_t   data_o,
  output logic   valid_o,
  output logic   err_o
);
  wires_t      lvl, ref_q, diff;
  int unsigned cnt;
  dec_t        res;
  logic        hit, over;
  logic        ack_q, valid_q, err_q;
  nib_t        data_q;

  tri_hex_sync #(.W(WIRES), .STAGES(SYNC_STAGES)) u_wire_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wires_i),
    .q_o   (lvl)
  );

  always_comb begin
    diff = lvl ^ ref_q;
    cnt  = ones(diff);
    res  = cw_dec(diff);
    hit  = (cnt == HOT);
    over = (cnt > HOT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (hit && res.ok) begin
        ref_q   <= lvl;
        ack_q   <= !ack_q;
        data_q  <= res.nib;
        valid_q <= 1'b1;
      end else if (hit || over) begin
        ref_q   <= lvl;     // resync on bad pattern
        ack_q   <= !ack_q;  // release sender anyway
        err_q   <= 1'b1;
      end
    end
  end

  assign ack_o   = ack_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/tri_hex_link.sv
module tri_hex_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [5:0] tx_wires_o,
  input  logic       tx_ack_i,
  input  logic [5:0] rx_wires_i,
  output logic       rx_ack_o,
  output logic [3:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_err_o
);
  tri_hex_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .wires_o(tx_wires_o),
    .ack_i  (tx_ack_i)
  );

  tri_hex_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wires_i(rx_wires_i),
    .ack_o  (rx_ack_o),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .err_o  (rx_err_o)
  );
endmodule

// File: rtl/tri_hex_link_chk.sv
module tri_hex_link_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] tx_data_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic [5:0] tx_wires_o,
  input logic       tx_ack_i,
  input logic [5:0] rx_wires_i,
  input logic       rx_ack_o,
  input logic [3:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_err_o
);
  logic hs;
  assign hs = tx_valid_i && tx_ready_o;

  // R2
  wires_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs |=> $stable(tx_wires_o));

  // R2
  three_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> ($countones(tx_wires_o ^ $past(tx_wires_o)) == 3));

  // R3
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> !tx_ready_o);

  // R8
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ack_o != $past(rx_ack_o)) |-> (rx_valid_o || rx_err_o));

  // R8
  ack_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o || rx_err_o) |-> (rx_ack_o != $past(rx_ack_o)));

  // R6
  valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o));

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_wires_o == 6'd0 && !rx_ack_o && !rx_valid_o && !rx_err_o));
endmodule

bind tri_hex_link tri_hex_link_chk u_chk (.*);

// File: tb/tri_hex_link_test.sv
module tri_hex_link_test;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int NV   = 20;
  // {nibble, expected codeword}
  localparam logic [9:0] VEC [NV] = '{
    {4'h0, 6'b000111}, {4'h1, 6'b001011}, {4'h2, 6'b001101}, {4'h3, 6'b001110},
    {4'h4, 6'b010011}, {4'h5, 6'b010101}, {4'h6, 6'b010110}, {4'h7, 6'b011001},
    {4'h8, 6'b011010}, {4'h9, 6'b011100}, {4'ha, 6'b100011}, {4'hb, 6'b100101},
    {4'hc, 6'b100110}, {4'hd, 6'b101001}, {4'he, 6'b101010}, {4'hf, 6'b101100},
    {4'h5, 6'b010101}, {4'h5, 6'b010101}, {4'hf, 6'b101100}, {4'h0, 6'b000111}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, rx_ack, rx_valid, rx_err;
  logic [5:0] tx_wires, flip = '0;
  logic [3:0] rx_data;
  int         cyc = 0, total = 0, bad = 0, vcnt = 0, ecnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_hex_link #(.SYNC_STAGES(SYNC)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tx_data_i (tx_data),
    .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready),
    .tx_wires_o(tx_wires),
    .tx_ack_i  (rx_ack),
    .rx_wires_i(tx_wires ^ flip),
    .rx_ack_o  (rx_ack),
    .rx_data_o (rx_data),
    .rx_valid_o(rx_valid),
    .rx_err_o  (rx_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) vcnt <= vcnt + 1;
    if (rx_err)   ecnt <= ecnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] nib, input logic [5:0] cw);
    logic [5:0] pre;
    logic       ack0;
    int         hs;
    bit         got;
    @(negedge clk);
    tx_data  = nib;
    tx_valid = 1'b1;
    for (int i = 0; i < 50 && !tx_ready; i++) @(negedge clk);
    hs   = cyc + 1;
    pre  = tx_wires;
    ack0 = rx_ack;
    @(negedge clk);
    tx_valid = 1'b0;
    chk((tx_wires ^ pre) == cw, "R1", "codeword", int'(tx_wires ^ pre), int'(cw));
    chk(!tx_ready, "R3", "ready after handshake", int'(tx_ready), 0);
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rx_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R4", "valid seen", int'(got), 1);
    chk(rx_data == nib, "R4", "decoded nibble", int'(rx_data), int'(nib));
    chk(cyc - hs == LAT, "R4", "latency", cyc - hs, LAT);
    chk(!tx_ready, "R3", "ready held until ack", int'(tx_ready), 0);
    chk(rx_ack != ack0, "R8", "ack toggled", int'(rx_ack), int'(!ack0));
    for (int i = 0; i < 20 && !tx_ready; i++) @(negedge clk);
    chk(tx_ready, "R3", "ready returns", int'(tx_ready), 1);
  endtask

  task automatic settle();
    for (int i = 0; i < 8; i++) @(negedge clk);
  endtask

  initial begin
    int v0, e0, c0;
    logic a0;
    logic [5:0] w0;
    bit got;
    repeat (3) @(negedge clk);
    chk(tx_wires == 6'd0, "R9", "wires in reset", int'(tx_wires), 0);
    chk(!rx_ack, "R9", "ack in reset", int'(rx_ack), 0);
    chk(!rx_valid && !rx_err, "R9", "pulses in reset", int'({rx_valid, rx_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready, "R9", "ready after reset", int'(tx_ready), 1);

    for (int k = 0; k < NV; k++) send(VEC[k][9:6], VEC[k][5:0]);

    // R5: transitions arriving in two steps
    v0 = vcnt; e0 = ecnt; a0 = rx_ack;
    @(negedge clk); flip = flip ^ 6'b000011;
    settle();
    chk(vcnt == v0 && ecnt == e0, "R5", "partial silent", vcnt - v0 + ecnt - e0, 0);
    chk(rx_ack == a0, "R5", "partial no ack", int'(rx_ack), int'(a0));
    flip = flip ^ 6'b000100;
    c0 = cyc;
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rx_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got && rx_data == 4'h0, "R5", "joined symbol", int'(rx_data), 0);
    chk(cyc - c0 == LAT, "R4", "latency of arriving wires", cyc - c0, LAT);
    settle();

    // R6: unused three-wire pattern
    v0 = vcnt; e0 = ecnt; a0 = rx_ack; w0 = tx_wires;
    flip = flip ^ 6'b110001;
    settle();
    chk(ecnt == e0 + 1, "R6", "unused pattern error", ecnt - e0, 1);
    chk(vcnt == v0, "R6", "no valid", vcnt - v0, 0);
    chk(rx_ack != a0, "R8", "ack on error", int'(rx_ack), int'(!a0));
    chk(tx_ready && tx_wires == w0, "R3", "idle ack ignored", int'(tx_ready), 1);

    // R7: four and six wire changes
    v0 = vcnt; e0 = ecnt; a0 = rx_ack;
    flip = flip ^ 6'b001111;
    settle();
    chk(ecnt == e0 + 1 && vcnt == v0, "R7", "four changes", ecnt - e0, 1);
    chk(rx_ack != a0, "R8", "ack on overcount", int'(rx_ack), int'(!a0));
    e0 = ecnt;
    flip = flip ^ 6'b111111;
    settle();
    chk(ecnt == e0 + 1 && vcnt == v0, "R7", "six changes", ecnt - e0, 1);

    // R10: clean decode after resync
    send(4'h9, 6'b011100);
    send(4'h3, 6'b001110);
    chk(ecnt == e0 + 1, "R10", "no stray error", ecnt - e0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule